// File: doc/BRIEF.md
# Eight-Point Inverse DCT Pipeline

This block turns one row of eight signed 16-bit frequency coefficients into eight signed 16-bit spatial samples. It uses a four-level butterfly factorisation. First, four pairs of coefficients are rotated by fixed Q15 cosine constants. Next, the even and odd halves go through add/subtract butterflies that halve their results with an arithmetic shift. In the third level, the outer outputs are formed and the middle odd difference pair is rotated by cos(pi/4). A last add/subtract level produces the four middle outputs.

A separable two-dimensional transform would use this block once on the rows and once on the columns. Any transposition and row sequencing stay outside the block. The block has a valid/ready handshake on each side. It holds one vector per stage in four register stages, so it accepts a new vector every cycle while the consumer keeps up. When the consumer stalls, the whole pipeline freezes.

Lane i of `in_coef` (bits [16i+15:16i]) carries coefficient index i. Lane n of `out_samp` carries spatial sample n in natural order. All lane values are two's complement.

Top module: `idct8_chen`

## Requirements
- R1: Reset is synchronous and active high. On the cycle after `rst` is sampled high, `out_valid` is low, and any vector in flight at that time never appears on the output.
- R2: `in_ready` is low only while `out_valid` is high and `out_ready` is low. While that holds, `out_valid` stays high and `out_samp` does not change at the next edge.
- R3: Suppose a vector is accepted at edge k and `out_ready` is high at edges k+1 to k+3. Then its result is on `out_samp` with `out_valid` high between edges k+3 and k+4. With `out_ready` held high, one vector enters and one leaves every cycle.
- R4: Each rotation output is the exact sum or difference of two 16x16 products, call it P. The output is floor((P + 2^14) / 2^15), saturated to [-32768, 32767].
- R5: Level one forms the following pairs, with the constants 0x5A82 for cos(pi/4), 0x7642 for cos(pi/8), 0x30FC for cos(3pi/8), 0x7D8A for cos(pi/16), 0x6A6E for cos(3pi/16), 0x471D for cos(5pi/16) and 0x18F9 for cos(7pi/16):
  - d = x0*cos(pi/4) - x4*cos(pi/4) and s = x4*cos(pi/4) + x0*cos(pi/4)
  - p = x2*cos(3pi/8) - x6*cos(pi/8) and q = x6*cos(3pi/8) + x2*cos(pi/8)
  - o5 = x5*cos(3pi/16) - x3*cos(5pi/16) and o3 = x3*cos(3pi/16) + x5*cos(5pi/16)
  - o1 = x1*cos(7pi/16) - x7*cos(pi/16) and o7 = x7*cos(7pi/16) + x1*cos(pi/16)
- R6: The halving butterflies give E4=(d+p)>>>1, E2=(d-p)>>>1, E0=(s+q)>>>1, E6=(s-q)>>>1, O1=(o1+o5)>>>1, Dh=(o1-o5)>>>1, O7=(o7+o3)>>>1 and Dl=(o7-o3)>>>1. Each is rounded toward minus infinity.
- R7: y0 = E0+O7, y7 = E0-O7, y3 = E6+O1 and y4 = E6-O1, each saturated to 16 bits.
- R8: mh is Dl*cos(pi/4) - Dh*cos(pi/4), and ml is Dh*cos(pi/4) + Dl*cos(pi/4), both rounded as in R4. Then y2 = E2+mh, y5 = E2-mh, y1 = E4+ml and y6 = E4-ml, each saturated to 16 bits.
- R9: Full-scale inputs saturate to 32767 or -32768 and never wrap. An input with every lane at 32767 gives y0 = 32767.
- R10: For inputs in [-256, 255], each output is within 4 LSB of the orthonormal inverse DCT y_n = sum_k (c_k/2) X_k cos((2n+1)k*pi/16), where c_0 = 1/sqrt(2) and c_k = 1 for k > 0. A lone coefficient in lane 0 gives eight equal outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block takes the vector at this edge |
| in_coef | input | 128 | Eight signed coefficients, lane i = index i |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_samp | output | 128 | Eight signed samples, lane n = position n |

## Verification
The hardest case to reach from the ports is the stall of a full pipeline. Here `in_ready` must drop exactly while a finished result waits, and four half-computed vectors must freeze without losing or repeating one. The bench streams vectors back to back while it drops `out_ready` on a pseudo-random pattern, and it checks every held cycle against the previous one. A second hard case is the saturating corners inside the middle butterflies, which normal coefficient ranges never reach. Full-scale vectors are sent to drive those adders past 16 bits.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int DW   = 16;            // sample width
    localparam int CW   = 16;            // constant width (Q15)
    localparam int FRAC = CW - 1;        // fractional bits of the constants
    localparam int NPT  = 8;             // points per vector
    localparam int AW   = DW + CW + 2;   // accumulator: two products plus headroom

    typedef logic signed [DW-1:0] samp_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [AW-1:0] acc_t;

    localparam coef_t K_PI4   = 16'sh5A82;
    localparam coef_t K_PI8   = 16'sh7642;
    localparam coef_t K_3PI8  = 16'sh30FC;
    localparam coef_t K_PI16  = 16'sh7D8A;
    localparam coef_t K_3PI16 = 16'sh6A6E;
    localparam coef_t K_5PI16 = 16'sh471D;
    localparam coef_t K_7PI16 = 16'sh18F9;

    localparam samp_t SMAX = 16'sh7FFF;
    localparam samp_t SMIN = 16'sh8000;

    typedef struct packed {
        samp_t hi;
        samp_t lo;
    } pair_t;

    // level-two results (after halving butterflies)
    typedef struct packed {
        samp_t e0, e6, e2, e4;
        samp_t o1, o7, dh, dl;
    } st2_t;

    // level-three results
    typedef struct packed {
        samp_t y0, y3, y4, y7;
        samp_t e2, e4, mh, ml;
    } st3_t;

    typedef samp_t [NPT-1:0] vec_t;

    function automatic samp_t sat_s(input acc_t v);
        if (v > acc_t'(SMAX)) return SMAX;
        if (v < acc_t'(SMIN)) return SMIN;
        return samp_t'(v);
    endfunction

    // a*ca +/- b*cb, rounded half up at bit FRAC-1, saturated
    function automatic samp_t rot_q15(input samp_t a, input coef_t ca,
                                      input samp_t b, input coef_t cb,
                                      input logic add_b);
        acc_t pa;
        acc_t pb;
        acc_t acc;
        pa  = acc_t'(a) * acc_t'(ca);
        pb  = acc_t'(b) * acc_t'(cb);
        acc = add_b ? (pa + pb) : (pa - pb);
        acc = acc + (acc_t'(1) <<< (FRAC - 1));
        return sat_s(acc >>> FRAC);
    endfunction

endpackage

// File: rtl/idct8_rotator.sv
module idct8_rotator
    import idct8_pkg::*;
#(
    parameter coef_t CA = K_PI4,
    parameter coef_t CB = K_PI4
) (
    input  samp_t a_i,
    input  samp_t b_i,
    output pair_t y_o
);

    always_comb begin
        y_o.hi = rot_q15(a_i, CA, b_i, CB, 1'b0);   // a*CA - b*CB
        y_o.lo = rot_q15(b_i, CA, a_i, CB, 1'b1);   // b*CA + a*CB
    end

    // a zero pair cannot produce anything but zero after rounding
    always_comb begin
        if (a_i == '0 && b_i == '0) begin
            assert_zero_rot_R4: assert (y_o == '0)
                else $error("rotator produced nonzero output from zero inputs");
        end
    end

endmodule

// File: rtl/idct8_bfly.sv
module idct8_bfly
    import idct8_pkg::*;
#(
    parameter bit HALVE = 1'b1
) (
    input  samp_t a_i,
    input  samp_t b_i,
    output samp_t sum_o,
    output samp_t dif_o
);

    acc_t s_w;
    acc_t d_w;

    generate
        if (HALVE) begin : g_half
            always_comb begin
                s_w = (acc_t'(a_i) + acc_t'(b_i)) >>> 1;
                d_w = (acc_t'(a_i) - acc_t'(b_i)) >>> 1;
            end
        end else begin : g_full
            always_comb begin
                s_w = acc_t'(a_i) + acc_t'(b_i);
                d_w = acc_t'(a_i) - acc_t'(b_i);
            end
        end
    endgenerate

    assign sum_o = sat_s(s_w);
    assign dif_o = sat_s(d_w);

    // floor((a+b)/2) - floor((a-b)/2) is always exactly b
    always_comb begin
        if (HALVE) begin
            assert_halve_pair_R6: assert ((acc_t'(sum_o) - acc_t'(dif_o)) == acc_t'(b_i))
                else $error("halving butterfly outputs inconsistent");
        end
    end

endmodule

// File: rtl/idct8_chen.sv
module idct8_chen
    import idct8_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NPT-1:0][DW-1:0] in_coef,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NPT-1:0][DW-1:0] out_samp
);

    localparam int NSTG = 4;
    localparam int NROT = 4;
    localparam int NBF  = 4;

    // level-one pairings: lane indices and constants
    localparam int    A_SEL [NROT] = '{0, 2, 5, 1};
    localparam int    B_SEL [NROT] = '{4, 6, 3, 7};
    localparam coef_t KA    [NROT] = '{K_PI4, K_3PI8, K_3PI16, K_7PI16};
    localparam coef_t KB    [NROT] = '{K_PI4, K_PI8,  K_5PI16, K_PI16};

    logic [NSTG-1:0]  vld_q;
    logic             adv;

    pair_t [NROT-1:0] rot_w;
    pair_t [NROT-1:0] s1_q;
    st2_t             s2_w, s2_q;
    st3_t             s3_w, s3_q;
    vec_t             s4_w, s4_q;

    samp_t [NBF-1:0]  bs_w, bd_w;
    pair_t            mid_w;

    // ---------------- flow control ----------------
    assign adv       = out_ready || !vld_q[NSTG-1];
    assign in_ready  = adv;
    assign out_valid = vld_q[NSTG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (adv) begin
            vld_q <= {vld_q[NSTG-2:0], in_valid};
        end
    end

    // ---------------- level one: rotations ----------------
    generate
        for (genvar g = 0; g < NROT; g++) begin : g_rot1
            idct8_rotator #(.CA(KA[g]), .CB(KB[g])) u_rot (
                .a_i (samp_t'(in_coef[A_SEL[g]])),
                .b_i (samp_t'(in_coef[B_SEL[g]])),
                .y_o (rot_w[g])
            );
        end
    endgenerate

    // ---------------- level two: halving butterflies ----------------
    // lanes 0/1 pair the even rotations (0,1); lanes 2/3 pair the odd ones (3,2)
    generate
        for (genvar j = 0; j < NBF; j++) begin : g_half
            localparam int PA = (j < 2) ? 0 : 3;
            localparam int PB = (j < 2) ? 1 : 2;
            idct8_bfly #(.HALVE(1'b1)) u_bf (
                .a_i   ((j % 2 == 0) ? s1_q[PA].hi : s1_q[PA].lo),
                .b_i   ((j % 2 == 0) ? s1_q[PB].hi : s1_q[PB].lo),
                .sum_o (bs_w[j]),
                .dif_o (bd_w[j])
            );
        end
    endgenerate

    always_comb begin
        s2_w.e4 = bs_w[0];
        s2_w.e2 = bd_w[0];
        s2_w.e0 = bs_w[1];
        s2_w.e6 = bd_w[1];
        s2_w.o1 = bs_w[2];
        s2_w.dh = bd_w[2];
        s2_w.o7 = bs_w[3];
        s2_w.dl = bd_w[3];
    end

    // ---------------- level three: outer outputs, middle rotation ----------------
    idct8_bfly #(.HALVE(1'b0)) u_b07 (
        .a_i (s2_q.e0), .b_i (s2_q.o7), .sum_o (s3_w.y0), .dif_o (s3_w.y7)
    );
    idct8_bfly #(.HALVE(1'b0)) u_b34 (
        .a_i (s2_q.e6), .b_i (s2_q.o1), .sum_o (s3_w.y3), .dif_o (s3_w.y4)
    );
    idct8_rotator #(.CA(K_PI4), .CB(K_PI4)) u_rot_mid (
        .a_i (s2_q.dl), .b_i (s2_q.dh), .y_o (mid_w)
    );

    always_comb begin
        s3_w.mh = mid_w.hi;
        s3_w.ml = mid_w.lo;
        s3_w.e2 = s2_q.e2;
        s3_w.e4 = s2_q.e4;
    end

    // ---------------- level four: middle outputs ----------------
    idct8_bfly #(.HALVE(1'b0)) u_b25 (
        .a_i (s3_q.e2), .b_i (s3_q.mh), .sum_o (s4_w[2]), .dif_o (s4_w[5])
    );
    idct8_bfly #(.HALVE(1'b0)) u_b16 (
        .a_i (s3_q.e4), .b_i (s3_q.ml), .sum_o (s4_w[1]), .dif_o (s4_w[6])
    );

    always_comb begin
        s4_w[0] = s3_q.y0;
        s4_w[3] = s3_q.y3;
        s4_w[4] = s3_q.y4;
        s4_w[7] = s3_q.y7;
    end

    // ---------------- pipeline registers ----------------
    always_ff @(posedge clk) begin
        if (adv) begin
            s1_q <= rot_w;
            s2_q <= s2_w;
            s3_q <= s3_w;
            s4_q <= s4_w;
        end
    end

    assign out_samp = s4_q;

    // ---------------- assertions ----------------
    assert_rst_clears_R1: assert property (@(posedge clk)
        rst |=> !out_valid)
        else $error("out_valid high after reset");

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_samp)))
        else $error("stalled result changed or vanished");

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 out_ready ##1 out_ready ##1 out_ready |=> out_valid)
        else $error("accepted vector missing after four stages");

endmodule

// File: tb/idct8_chen_tb.sv
module idct8_chen_tb_top;

    typedef logic [7:0][15:0] vec_t;

    localparam longint C4   = 23170;
    localparam longint CP8  = 30274;
    localparam longint C3P8 = 12540;
    localparam longint CP16 = 32138;
    localparam longint C3P16 = 27246;
    localparam longint C5P16 = 18205;
    localparam longint C7P16 = 6393;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    vec_t in_coef = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    vec_t out_samp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    vec_t  exp_q[$];
    vec_t  inp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    idct8_chen dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_coef   (in_coef),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_samp  (out_samp)
    );

    // ---------------- arithmetic model from the requirements ----------------
    function automatic longint sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rq(input longint a, input longint ca,
                                  input longint b, input longint cb, input bit plus);
        longint p;
        p = plus ? (a * ca + b * cb) : (a * ca - b * cb);
        return sat((p + 16384) >>> 15);
    endfunction

    function automatic vec_t model(input vec_t x);
        longint v[8];
        longint d, s, p, q, o1, o3, o5, o7;
        longint e0, e2, e4, e6, h1, h7, dh, dl, mh, ml;
        vec_t y;
        for (int i = 0; i < 8; i++) v[i] = longint'($signed(x[i]));
        d  = rq(v[0], C4, v[4], C4, 0);     s  = rq(v[4], C4, v[0], C4, 1);
        p  = rq(v[2], C3P8, v[6], CP8, 0);  q  = rq(v[6], C3P8, v[2], CP8, 1);
        o5 = rq(v[5], C3P16, v[3], C5P16, 0); o3 = rq(v[3], C3P16, v[5], C5P16, 1);
        o1 = rq(v[1], C7P16, v[7], CP16, 0);  o7 = rq(v[7], C7P16, v[1], CP16, 1);
        e4 = (d + p) >>> 1;  e2 = (d - p) >>> 1;
        e0 = (s + q) >>> 1;  e6 = (s - q) >>> 1;
        h1 = (o1 + o5) >>> 1; dh = (o1 - o5) >>> 1;
        h7 = (o7 + o3) >>> 1; dl = (o7 - o3) >>> 1;
        mh = rq(dl, C4, dh, C4, 0);
        ml = rq(dh, C4, dl, C4, 1);
        y[0] = 16'(sat(e0 + h7)); y[7] = 16'(sat(e0 - h7));
        y[3] = 16'(sat(e6 + h1)); y[4] = 16'(sat(e6 - h1));
        y[2] = 16'(sat(e2 + mh)); y[5] = 16'(sat(e2 - mh));
        y[1] = 16'(sat(e4 + ml)); y[6] = 16'(sat(e4 - ml));
        return y;
    endfunction

    function automatic real ref_idct(input vec_t x, input int n);
        real acc, ck;
        acc = 0.0;
        for (int k = 0; k < 8; k++) begin
            ck = (k == 0) ? 0.70710678118654752 : 1.0;
            acc = acc + ck / 2.0 * real'($signed(x[k]))
                  * $cos(real'((2 * n + 1) * k) * 3.14159265358979324 / 16.0);
        end
        return acc;
    endfunction

    function automatic bit small_range(input vec_t x);
        for (int i = 0; i < 8; i++)
            if ($signed(x[i]) < -256 || $signed(x[i]) > 255) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // ---------------- scoreboard ----------------
    task automatic consume();
        vec_t e, x;
        string t, tg;
        real err, worst;
        bit lone;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3", "result with no accepted vector", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        x = inp_q.pop_front();
        t = tag_q.pop_front();
        for (int i = 0; i < 8; i++) begin
            if (t == "LANE") tg = (i == 0 || i == 3 || i == 4 || i == 7) ? "R7" : "R8";
            else tg = t;
            check(out_samp[i] == e[i], tg, $sformatf("lane %0d", i),
                  longint'($signed(out_samp[i])), longint'($signed(e[i])));
        end
        if (small_range(x)) begin
            worst = 0.0;
            for (int i = 0; i < 8; i++) begin
                err = real'($signed(out_samp[i])) - ref_idct(x, i);
                if (err < 0.0) err = -err;
                if (err > worst) worst = err;
            end
            check(worst <= 4.0, "R10", "max error vs real transform x100",
                  longint'($rtoi(worst * 100.0)), 400);
        end
        lone = (x[0] != '0);
        for (int i = 1; i < 8; i++) if (x[i] != '0) lone = 1'b0;
        if (lone)
            for (int i = 1; i < 8; i++)
                check(out_samp[i] == out_samp[0], "R10", $sformatf("flat lane %0d", i),
                      longint'($signed(out_samp[i])), longint'($signed(out_samp[0])));
    endtask

    // one cycle, entered and left at a falling edge
    task automatic step(input bit v, input vec_t d, input bit rdy, input string tag,
                        output bit took);
        bit   hold;
        vec_t held;
        in_valid  = v;
        in_coef   = d;
        out_ready = rdy;
        #1;
        check(in_ready == !(out_valid && !rdy), "R2", "in_ready",
              longint'(in_ready), longint'(!(out_valid && !rdy)));
        hold = out_valid && !rdy;
        held = out_samp;
        if (out_valid && rdy) consume();
        took = v && in_ready;
        if (took) begin
            exp_q.push_back(model(d));
            inp_q.push_back(d);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        @(negedge clk);
        if (hold) begin
            check(out_valid == 1'b1, "R2", "valid during stall", longint'(out_valid), 1);
            check(out_samp == held, "R2", "lane 0 during stall",
                  longint'($signed(out_samp[0])), longint'($signed(held[0])));
        end
    endtask

    task automatic send(input vec_t d, input string tag, input bit rnd_rdy, output int tries);
        bit took;
        tries = 0;
        took  = 1'b0;
        while (!took && tries < 50) begin
            step(1'b1, d, rnd_rdy ? ($urandom_range(0, 9) < 7) : 1'b1, tag, took);
            tries++;
        end
    endtask

    task automatic drain(output int steps);
        bit took;
        steps = 0;
        while (exp_q.size() > 0 && steps < 200) begin
            step(1'b0, '0, 1'b1, "R3", took);
            steps++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        vec_t x;
        int   tries, total, steps;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R2", "in_ready with empty pipe", longint'(in_ready), 1);

        // R3: exact latency of one vector
        x = '0;
        x[0] = 16'(100); x[3] = 16'(-37); x[6] = 16'(211);
        in_valid = 1'b1; in_coef = x; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int n = 1; n <= 5; n++) begin
            check(out_valid == (n == 4), "R3", $sformatf("out_valid %0d cycles after accept", n),
                  longint'(out_valid), longint'(n == 4));
            if (n == 4)
                check(out_samp == model(x), "R3", "latency result lane 0",
                      longint'($signed(out_samp[0])), longint'($signed(model(x)[0])));
            @(negedge clk);
        end

        // R5: single-coefficient vectors, back to back, ready held high
        total = 0;
        for (int pos = 0; pos < 8; pos++) begin
            for (int a = 0; a < 6; a++) begin
                x = '0;
                case (a)
                    0: x[pos] = 16'(-256);
                    1: x[pos] = 16'(255);
                    2: x[pos] = 16'(1);
                    3: x[pos] = 16'(-1);
                    4: x[pos] = 16'(97);
                    default: x[pos] = 16'(-131);
                endcase
                send(x, "R5", 1'b0, tries);
                total += tries;
            end
        end
        drain(steps);
        // R3: 48 vectors should leave in 48 + 4 cycles with no refusal
        check(total + steps == 48 + 4, "R3", "cycles for 48 back-to-back vectors",
              total + steps, 52);

        // R4: ramp sweep covering every in-range value on every lane
        for (int i = 0; i < 512; i++) begin
            for (int k = 0; k < 8; k++) x[k] = 16'(((i * 37 + k * 53) % 512) - 256);
            send(x, "R4", 1'b0, tries);
        end
        drain(steps);

        // R6: odd-only vectors, the halving butterflies of the odd half
        for (int i = 0; i < 300; i++) begin
            x = '0;
            x[1] = 16'($urandom_range(0, 511) - 256);
            x[3] = 16'($urandom_range(0, 511) - 256);
            x[5] = 16'($urandom_range(0, 511) - 256);
            x[7] = 16'($urandom_range(0, 511) - 256);
            send(x, "R6", 1'b0, tries);
        end
        drain(steps);

        // R7 / R8 with R2 stalls: full random vectors, random out_ready
        for (int i = 0; i < 600; i++) begin
            for (int k = 0; k < 8; k++) x[k] = 16'($urandom_range(0, 511) - 256);
            send(x, "LANE", 1'b1, tries);
        end
        drain(steps);

        // R9: full-scale vectors exercising saturation
        x = {8{16'h7FFF}};
        send(x, "R9", 1'b0, tries);
        for (int i = 0; i < 200; i++) begin
            for (int k = 0; k < 8; k++) begin
                case ($urandom_range(0, 2))
                    0: x[k] = 16'h7FFF;
                    1: x[k] = 16'h8000;
                    default: x[k] = 16'($urandom_range(0, 65535));
                endcase
            end
            send(x, "R9", 1'b1, tries);
        end
        drain(steps);

        // R9: directed all-max vector, y0 pinned at the positive limit
        x = {8{16'h7FFF}};
        in_valid = 1'b1; in_coef = x; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid && $signed(out_samp[0]) == 32767, "R9", "y0 for all-max input",
              longint'($signed(out_samp[0])), 32767);
        @(negedge clk);

        // R1: reset with vectors in flight, output held back
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_coef  = {8{16'(i + 5)}};
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R1", "out_valid after mid-stream reset", longint'(out_valid), 0);
        out_ready = 1'b1;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "flushed vector reappeared", longint'(out_valid), 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule